// File: doc/BRIEF.md
# Multiplexed Character Display Controller

This block sits between a processor write port and a multiplexed character display. The processor writes 6-bit character codes into an eight-entry character store. In one mode the block picks the location itself from a location counter that advances on each write. In the other mode the processor supplies the location with each write. The block drives one character-select line at a time. It presents the code for the selected character to a segment decoder downstream, and it leaves a blank gap between successive characters.

In sequential mode the first character after a clear lands in the left-most position, location 0. Each later character lands one position to the right. After eight such entries a full flag rises. A second controller placed behind this one can use that flag to take over the stream. A clear input fills the store with the space code and rewinds the counter. While a write strobe is high, the scan stands still with every select line off. The scan picks up again at the same spot once the strobe has dropped.

Top module: `chardisp_ctrl`

## Requirements
- R1: After reset every location holds code 6'h20, `disp_full` is 0, the scan starts in the strobe phase of position 0 (`char_sel` = 8'h01), and the first sequential write goes to location 0.
- R2: A write (`wr_en` = 1 at a rising clock edge) with `seq_mode` = 1 stores `wr_data` at the location counter's current value, then advances the counter by one. Location k is shown on `char_sel[k]`, where bit 0 is the left-most position.
- R3: `disp_full` rises on the clock edge of the eighth sequential write after reset or clear, and not before.
- R4: A sequential write while `disp_full` = 1 changes no location.
- R5: A write with `seq_mode` = 0 stores `wr_data` at location `wr_addr`.
- R6: Writes with `seq_mode` = 0 leave both the location counter and `disp_full` unchanged.
- R7: `clear` = 1 at a clock edge sets every location to 6'h20, returns the counter to 0 and drops `disp_full`. It takes priority over a write in the same cycle, and that write is discarded.
- R8: Each scan slot drives `char_sel` one-hot at the slot's position for STROBE_CLKS clocks, with `char_code` equal to that location's contents. Then `char_sel` is 0 for BLANK_CLKS clocks. Positions advance 0 to 7 and wrap around.
- R9: `char_sel` is 0 while `wr_en` is high and for one clock after it falls. The scan then resumes at the same position and phase, and no timer counts are lost.
- R10: `char_code` changes only while `char_sel` is 0, except when a clear rewrites the store.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en | input | 1 | Write strobe; one write per clock while high; also holds the scan |
| seq_mode | input | 1 | 1 = sequential (counter-addressed), 0 = processor-addressed |
| wr_addr | input | 3 | Location for processor-addressed writes |
| wr_data | input | 6 | Character code to store |
| clear | input | 1 | Synchronous clear of store, counter and full flag |
| char_sel | output | 8 | One-hot character-select strobes, bit 0 left-most |
| char_code | output | 6 | Code of the currently scanned character |
| disp_full | output | 1 | Eight sequential entries stored |

## Verification
A location counter that is off shows up on the very next scan frame, because a character sits in the wrong slot. In sequential mode it also shows up as `disp_full` rising one write early or late. A bad store entry appears as a wrong `char_code` within one frame, which is at most 8 × (STROBE_CLKS + BLANK_CLKS) clocks. A bad scan timer or position register shows up within one slot: the strobe is too long or too short, a select is skipped, or a select line is active during a write or in the clock after it.

// File: rtl/chardisp_pkg.sv
package chardisp_pkg;
  typedef enum logic {
    PH_STROBE = 1'b0,
    PH_BLANK  = 1'b1
  } scan_phase_e;
endpackage

// File: rtl/chardisp_rst_sync.sv
module chardisp_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/chardisp_wr_ctrl.sv
module chardisp_wr_ctrl #(
  parameter int DEPTH  = 8,
  parameter int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              seq_mode,
  input  logic              clear,
  input  logic [ADDR_W-1:0] wr_addr,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              full
);
  localparam logic [ADDR_W-1:0] LAST_LOC = ADDR_W'(DEPTH - 1);

  logic [ADDR_W-1:0] loc_q, loc_d;
  logic              full_q, full_d;
  logic              seq_go, rnd_go, upd_en;

  always_comb begin
    seq_go   = wr_en & seq_mode & ~full_q;
    rnd_go   = wr_en & ~seq_mode;
    mem_we   = (seq_go | rnd_go) & ~clear;
    mem_addr = seq_mode ? loc_q : wr_addr;
    upd_en   = clear | seq_go;
    loc_d    = loc_q;
    full_d   = full_q;
    if (clear) begin
      loc_d  = '0;
      full_d = 1'b0;
    end else if (seq_go) begin
      if (loc_q == LAST_LOC) begin
        loc_d  = '0;
        full_d = 1'b1;
      end else begin
        loc_d  = loc_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loc_q  <= '0;
      full_q <= 1'b0;
    end else if (upd_en) begin
      loc_q  <= loc_d;
      full_q <= full_d;
    end
  end

  assign full = full_q;
endmodule

// File: rtl/chardisp_mem.sv
module chardisp_mem #(
  parameter int                 DEPTH      = 8,
  parameter int                 CODE_W     = 6,
  parameter int                 ADDR_W     = $clog2(DEPTH),
  parameter logic [CODE_W-1:0]  BLANK_CODE = 6'h20
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [CODE_W-1:0] wdata,
  input  logic [ADDR_W-1:0] raddr,
  output logic [CODE_W-1:0] rdata
);
  logic [DEPTH-1:0][CODE_W-1:0] store_q, store_d;
  logic                         store_en;

  always_comb begin
    store_en = clear | we;
    store_d  = store_q;
    for (int i = 0; i < DEPTH; i++) begin
      if (clear)                          store_d[i] = BLANK_CODE;
      else if (we && waddr == ADDR_W'(i)) store_d[i] = wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) store_q[i] <= BLANK_CODE;
    end else if (store_en) begin
      store_q <= store_d;
    end
  end

  assign rdata = store_q[raddr];
endmodule

// File: rtl/chardisp_scan.sv
module chardisp_scan
  import chardisp_pkg::*;
#(
  parameter int DEPTH       = 8,
  parameter int STROBE_CLKS = 16,
  parameter int BLANK_CLKS  = 4,
  parameter int ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hold_in,
  output logic [DEPTH-1:0]  sel,
  output logic [ADDR_W-1:0] pos
);
  localparam int MAX_CLKS = (STROBE_CLKS > BLANK_CLKS) ? STROBE_CLKS : BLANK_CLKS;
  localparam int CNT_W    = $clog2(MAX_CLKS) + 1;
  localparam logic [CNT_W-1:0] STR_LAST = CNT_W'(STROBE_CLKS - 1);
  localparam logic [CNT_W-1:0] BLK_LAST = CNT_W'(BLANK_CLKS - 1);
  localparam logic [ADDR_W-1:0] POS_LAST = ADDR_W'(DEPTH - 1);

  scan_phase_e       phase_q, phase_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic [ADDR_W-1:0] pos_q, pos_d;
  logic              hold_q;
  logic              hold;
  logic              run_en;

  always_comb begin
    hold    = hold_in | hold_q;
    run_en  = ~hold;
    phase_d = phase_q;
    cnt_d   = cnt_q + 1'b1;
    pos_d   = pos_q;
    if (phase_q == PH_STROBE) begin
      if (cnt_q == STR_LAST) begin
        phase_d = PH_BLANK;
        cnt_d   = '0;
        pos_d   = (pos_q == POS_LAST) ? '0 : pos_q + 1'b1;
      end
    end else begin
      if (cnt_q == BLK_LAST) begin
        phase_d = PH_STROBE;
        cnt_d   = '0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hold_q <= 1'b0;
    else        hold_q <= hold_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_STROBE;
      cnt_q   <= '0;
      pos_q   <= '0;
    end else if (run_en) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      pos_q   <= pos_d;
    end
  end

  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_sel
      assign sel[g] = ~hold & (phase_q == PH_STROBE) & (pos_q == ADDR_W'(g));
    end
  endgenerate

  assign pos = pos_q;
endmodule

// File: rtl/chardisp_ctrl.sv
module chardisp_ctrl #(
  parameter int                CODE_W      = 6,
  parameter int                DEPTH       = 8,
  parameter int                STROBE_CLKS = 16,
  parameter int                BLANK_CLKS  = 4,
  parameter logic [CODE_W-1:0] BLANK_CODE  = 6'h20,
  parameter int                ADDR_W      = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              seq_mode,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CODE_W-1:0] wr_data,
  input  logic              clear,
  output logic [DEPTH-1:0]  char_sel,
  output logic [CODE_W-1:0] char_code,
  output logic              disp_full
);
  logic              rst_sync_n;
  logic              mem_we;
  logic [ADDR_W-1:0] mem_addr;
  logic [ADDR_W-1:0] scan_pos;

  chardisp_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  chardisp_wr_ctrl #(.DEPTH(DEPTH), .ADDR_W(ADDR_W)) u_wr (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .wr_en    (wr_en),
    .seq_mode (seq_mode),
    .clear    (clear),
    .wr_addr  (wr_addr),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .full     (disp_full)
  );

  chardisp_mem #(
    .DEPTH(DEPTH), .CODE_W(CODE_W), .ADDR_W(ADDR_W), .BLANK_CODE(BLANK_CODE)
  ) u_mem (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .clear (clear),
    .we    (mem_we),
    .waddr (mem_addr),
    .wdata (wr_data),
    .raddr (scan_pos),
    .rdata (char_code)
  );

  chardisp_scan #(
    .DEPTH(DEPTH), .STROBE_CLKS(STROBE_CLKS), .BLANK_CLKS(BLANK_CLKS), .ADDR_W(ADDR_W)
  ) u_scan (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .hold_in (wr_en),
    .sel     (char_sel),
    .pos     (scan_pos)
  );
endmodule

// File: rtl/chardisp_ctrl_chk.sv
module chardisp_ctrl_chk #(
  parameter int CODE_W = 6,
  parameter int DEPTH  = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic              seq_mode,
  input logic              clear,
  input logic [DEPTH-1:0]  char_sel,
  input logic [CODE_W-1:0] char_code,
  input logic              disp_full
);
  p_sel_onehot_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(char_sel));

  p_write_blanks_r9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (char_sel == '0));

  p_after_write_blank_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (char_sel == '0));

  p_code_steady_r10: assert property (@(posedge clk) disable iff (!rst_n)
    ((char_sel != '0) && ($past(char_sel) != '0) && !$past(clear)) |-> $stable(char_code));

  p_full_rise_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disp_full) |-> $past(wr_en && seq_mode && !clear));

  p_full_drop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(disp_full) |-> $past(clear));
endmodule

bind chardisp_ctrl chardisp_ctrl_chk #(.CODE_W(CODE_W), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .seq_mode  (seq_mode),
  .clear     (clear),
  .char_sel  (char_sel),
  .char_code (char_code),
  .disp_full (disp_full)
);

// File: tb/chardisp_ctrl_tb.sv
module chardisp_ctrl_tb;
  localparam int S = 3;
  localparam int B = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en, seq_mode, clear;
  logic [2:0] wr_addr;
  logic [5:0] wr_data;
  logic [7:0] char_sel;
  logic [5:0] char_code;
  logic       disp_full;

  int         n_chk = 0;
  int         n_err = 0;
  logic [5:0] exp_mem [8];
  int         exp_loc;
  bit         exp_full;

  always #2 clk = ~clk;

  chardisp_ctrl #(.STROBE_CLKS(S), .BLANK_CLKS(B)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .seq_mode(seq_mode),
    .wr_addr(wr_addr), .wr_data(wr_data), .clear(clear),
    .char_sel(char_sel), .char_code(char_code), .disp_full(disp_full)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic model_clear();
    for (int i = 0; i < 8; i++) exp_mem[i] = 6'h20;
    exp_loc  = 0;
    exp_full = 1'b0;
  endtask

  // one write cycle; returns at the negedge after the capturing edge
  task automatic do_write(input bit seq, input int addr, input int data);
    wr_en    = 1'b1;
    seq_mode = seq;
    wr_addr  = 3'(addr);
    wr_data  = 6'(data);
    @(negedge clk);
    wr_en = 1'b0;
    if (seq) begin
      if (!exp_full) begin
        exp_mem[exp_loc] = 6'(data);
        exp_loc++;
        if (exp_loc == 8) begin
          exp_loc  = 0;
          exp_full = 1'b1;
        end
      end
    end else begin
      exp_mem[addr] = 6'(data);
    end
  endtask

  task automatic do_clear();
    clear = 1'b1;
    @(negedge clk);
    clear = 1'b0;
    model_clear();
  endtask

  // sync to a slot start, then check two full frames of slots
  task automatic scan_frames(input string req);
    int p;
    int guard;
    guard = 0;
    while (char_sel != 8'h00 && guard < 100) begin @(negedge clk); guard++; end
    while (char_sel == 8'h00 && guard < 200) begin @(negedge clk); guard++; end
    p = 0;
    for (int k = 0; k < 8; k++) if (char_sel[k]) p = k;
    for (int slot = 0; slot < 16; slot++) begin
      for (int i = 0; i < S; i++) begin
        chk(char_sel == (8'h01 << p), {req, " R8 sel"}, char_sel, 8'h01 << p);
        chk(char_code == exp_mem[p], {req, " code"}, char_code, exp_mem[p]);
        @(negedge clk);
      end
      for (int i = 0; i < B; i++) begin
        chk(char_sel == 8'h00, {req, " R8 blank"}, char_sel, 0);
        @(negedge clk);
      end
      p = (p + 1) % 8;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 200000, 0);
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    int p;
    rst_n = 1'b0; wr_en = 1'b0; seq_mode = 1'b1; clear = 1'b0;
    wr_addr = '0; wr_data = '0;
    model_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(char_sel == 8'h01, "R1 first strobe", char_sel, 8'h01);
    chk(disp_full == 1'b0, "R1 full", disp_full, 0);
    scan_frames("R1 blank store");

    // R2 / R3 sequential fill
    for (int n = 0; n < 8; n++) begin
      chk(disp_full == 1'b0, "R3 not yet full", disp_full, 0);
      do_write(1'b1, 0, 6'h30 + n);
    end
    chk(disp_full == 1'b1, "R3 full after eight", disp_full, 1);
    scan_frames("R2 sequential order");

    // R4 ignored while full
    do_write(1'b1, 0, 6'h3f);
    chk(disp_full == 1'b1, "R4 full held", disp_full, 1);
    scan_frames("R4 store unchanged");

    // R5 / R6 random write while full keeps flag
    do_write(1'b0, 5, 6'h0a);
    chk(disp_full == 1'b1, "R6 full unchanged", disp_full, 1);
    scan_frames("R5 random write");

    // R7 clear
    do_clear();
    chk(disp_full == 1'b0, "R7 full cleared", disp_full, 0);
    scan_frames("R7 cleared store");

    // R6 random write leaves counter alone
    do_write(1'b1, 0, 6'h11);
    do_write(1'b0, 6, 6'h12);
    do_write(1'b1, 0, 6'h13);
    chk(disp_full == 1'b0, "R6 full stays low", disp_full, 0);
    scan_frames("R6 counter kept");

    // R7 clear beats simultaneous write
    clear = 1'b1; wr_en = 1'b1; seq_mode = 1'b1; wr_data = 6'h15;
    @(negedge clk);
    clear = 1'b0; wr_en = 1'b0;
    model_clear();
    do_write(1'b1, 0, 6'h21);
    scan_frames("R7 clear priority");

    // R5 sweep every address
    for (int a = 0; a < 8; a++) do_write(1'b0, a, 6'h01 + 7 * a);
    scan_frames("R5 address sweep");

    // R9 hold during write, resume same slot
    while (char_sel == 8'h00) @(negedge clk);
    p = 0;
    for (int k = 0; k < 8; k++) if (char_sel[k]) p = k;
    wr_en = 1'b1; seq_mode = 1'b0; wr_addr = 3'(p); wr_data = 6'h2a;
    #1 chk(char_sel == 8'h00, "R9 blank on strobe", char_sel, 0);
    @(negedge clk);
    chk(char_sel == 8'h00, "R9 blank held", char_sel, 0);
    wr_en = 1'b0;
    exp_mem[p] = 6'h2a;
    #1 chk(char_sel == 8'h00, "R9 blank one clock after", char_sel, 0);
    @(negedge clk);
    chk(char_sel == (8'h01 << p), "R9 resume same position", char_sel, 8'h01 << p);
    chk(char_code == 6'h2a, "R9 R5 new code", char_code, 6'h2a);
    scan_frames("R9 after hold");

    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule